// File: doc/BRIEF.md
# Dual Five-Input Lookup Cell with Fast Combining Gates

This block is a configurable logic cell. It holds four 16-entry truth tables in configuration storage, which is loaded one bit per clock through a serial shift port. The four tables pair up into two independent five-input functions. Function A reads inputs `a_in` and drives `fa_out`. Function B reads `b_in` and drives `fb_out`.

Two fast gates merge the two function results with a third input, `bypass_in`. This input reaches the gates without passing through any table, so it has the shortest path through the cell. Chains of cells can therefore be cascaded through it.

The first gate is either a 2:1 multiplexer or a three-way exclusive-OR, chosen by a configuration bit. Its result appears on `gsel_out`. The second gate is a three-input NAND, and its result appears on `gnand_out`. The raw function results stay on their own outputs while the gates are in use.

A second configuration bit selects whole-cell five-input operation. When that bit is clear, the cell acts as two plain four-input lookups and the combining gates are held low. The lookup path and the gates are purely combinational; only the configuration store is clocked.

Top module: `dlut_cell`

## Requirements
- R1: A synchronous active-high `rst` clears all 66 configuration bits. With a cleared configuration, all four outputs read 0 for every input value.
- R2: While `cfg_en` is 1, each rising clock edge shifts `cfg_din` into configuration bit 0 and moves every bit up one place. A full load takes 66 edges, most significant bit first.
- R2 (layout): bit 65 is the five-input enable. Bit 64 is the gate select (0 = multiplexer, 1 = exclusive-OR). Bits 63:48 hold A-high, 47:32 hold A-low, 31:16 hold B-high and 15:0 hold B-low. Entry n of a table is the bit at its base plus n.
- R3: While `cfg_en` is 0, the configuration holds, whatever `cfg_din` does.
- R4: In five-input mode, `fa_out` equals entry `a_in[3:0]` of A-high when `a_in[4]` is 1, and entry `a_in[3:0]` of A-low when `a_in[4]` is 0.
- R5: In five-input mode, `fb_out` is selected in the same way from B-high and B-low by `b_in`.
- R6: In five-input mode with gate select 0, `gsel_out` equals `fa_out` when `bypass_in` is 1, and `fb_out` when `bypass_in` is 0.
- R7: In five-input mode with gate select 1, `gsel_out` equals `fa_out ^ fb_out ^ bypass_in`.
- R8: In five-input mode, `gnand_out` equals the NAND of `fa_out`, `fb_out` and `bypass_in`, whichever gate select is set.
- R9: With the five-input enable at 0, `gsel_out` and `gnand_out` are 0. `fa_out` is entry `a_in[3:0]` of A-low and `fb_out` is entry `b_in[3:0]` of B-low. `a_in[4]` and `b_in[4]` have no effect.
- R10: `fa_out` and `fb_out` do not depend on `bypass_in` or on the gate select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst | input | 1 | Synchronous active-high reset of the configuration |
| cfg_en | input | 1 | Shift enable for configuration loading |
| cfg_din | input | 1 | Serial configuration data, most significant bit first |
| a_in | input | 5 | Inputs of function A |
| b_in | input | 5 | Inputs of function B |
| bypass_in | input | 1 | Fast third input of the combining gates |
| fa_out | output | 1 | Raw result of function A |
| fb_out | output | 1 | Raw result of function B |
| gsel_out | output | 1 | Multiplexer or exclusive-OR gate result |
| gnand_out | output | 1 | Three-input NAND gate result |

## Verification
The bench builds the cell with its default table address width of four. Each function then has five inputs, so the full space of `a_in`, `b_in` and `bypass_in` is only 2048 combinations. At this size, every scenario can sweep the complete input space and compare all four outputs against a model computed from the loaded configuration word. The scenarios cover multiplexer mode, exclusive-OR mode and four-input mode, with random and fixed tables. They also cover reset after a load and a hold period in which `cfg_din` toggles while `cfg_en` is low.

// File: rtl/dlut_pkg.sv
package dlut_pkg;

    localparam int TBL_AW_DEF = 4;
    localparam int N_TBL      = 4;
    localparam int MODE_BITS  = 2;

    typedef enum logic {
        GATE_MUX = 1'b0,
        GATE_XOR = 1'b1
    } gate_sel_e;

    typedef struct packed {
        logic      five_en;
        gate_sel_e gate_sel;
    } cell_mode_t;

    // Index of each table inside the configuration word, lowest first.
    localparam int TBL_B_LO = 0;
    localparam int TBL_B_HI = 1;
    localparam int TBL_A_LO = 2;
    localparam int TBL_A_HI = 3;

    function automatic int cfg_width(input int aw);
        return N_TBL * (1 << aw) + MODE_BITS;
    endfunction

endpackage

// File: rtl/dlut_cfg_chain.sv
module dlut_cfg_chain #(
    parameter int CFG_W = 66
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_din,
    output logic [CFG_W-1:0] cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_en) begin
            cfg_q <= {cfg_q[CFG_W-2:0], cfg_din};
        end
    end

    // R1: reset leaves an empty configuration
    p_reset_clears_r1: assert property (@(posedge clk) rst |=> (cfg_q == '0));

    // R2: the serial bit enters at position 0 and older bits move up
    p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cfg_q[0] == $past(cfg_din)) &&
                   (cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-2:0])));

    // R3: no load means no change
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_q));

endmodule

// File: rtl/dlut_fn5.sv
module dlut_fn5 #(
    parameter int TBL_AW = 4,
    localparam int DEPTH = 1 << TBL_AW
) (
    input  logic [DEPTH-1:0] tbl_lo,
    input  logic [DEPTH-1:0] tbl_hi,
    input  logic [TBL_AW:0]  sel_in,
    input  logic             five_en,
    output logic             f_out
);

    logic [TBL_AW-1:0] idx;
    logic              lo_bit;
    logic              hi_bit;

    always_comb begin
        idx    = sel_in[TBL_AW-1:0];
        lo_bit = tbl_lo[idx];
        hi_bit = tbl_hi[idx];
        // The top input picks the table only in five-input operation.
        if (five_en && sel_in[TBL_AW]) begin
            f_out = hi_bit;
        end else begin
            f_out = lo_bit;
        end
    end

endmodule

// File: rtl/dlut_combine.sv
module dlut_combine
    import dlut_pkg::*;
(
    input  cell_mode_t mode,
    input  logic       f_a,
    input  logic       f_b,
    input  logic       bypass,
    output logic       g_sel,
    output logic       g_nand
);

    logic mux_v;
    logic xor_v;

    always_comb begin
        mux_v = bypass ? f_a : f_b;
        xor_v = f_a ^ f_b ^ bypass;
        if (!mode.five_en) begin
            g_sel  = 1'b0;
            g_nand = 1'b0;
        end else begin
            g_sel  = (mode.gate_sel == GATE_XOR) ? xor_v : mux_v;
            g_nand = ~(f_a & f_b & bypass);
        end
    end

endmodule

// File: rtl/dlut_cell.sv
module dlut_cell
    import dlut_pkg::*;
#(
    parameter int TBL_AW = TBL_AW_DEF,
    localparam int DEPTH = 1 << TBL_AW,
    localparam int CFG_W = N_TBL * DEPTH + MODE_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic          cfg_din,
    input  logic [TBL_AW:0] a_in,
    input  logic [TBL_AW:0] b_in,
    input  logic          bypass_in,
    output logic          fa_out,
    output logic          fb_out,
    output logic          gsel_out,
    output logic          gnand_out
);

    logic [CFG_W-1:0] cfg_q;
    cell_mode_t       mode;
    logic [DEPTH-1:0] tbl [N_TBL];
    logic [1:0]       fn_res;
    logic [TBL_AW:0]  fn_sel [2];

    dlut_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_en (cfg_en),
        .cfg_din(cfg_din),
        .cfg_q  (cfg_q)
    );

    assign mode = cell_mode_t'(cfg_q[CFG_W-1 -: MODE_BITS]);

    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        assign tbl[t] = cfg_q[t*DEPTH +: DEPTH];
    end

    // Function 0 is B (tables 0/1), function 1 is A (tables 2/3).
    assign fn_sel[0] = b_in;
    assign fn_sel[1] = a_in;

    for (genvar k = 0; k < 2; k++) begin : g_fn
        dlut_fn5 #(.TBL_AW(TBL_AW)) u_fn (
            .tbl_lo (tbl[2*k]),
            .tbl_hi (tbl[2*k+1]),
            .sel_in (fn_sel[k]),
            .five_en(mode.five_en),
            .f_out  (fn_res[k])
        );
    end

    assign fa_out = fn_res[1];
    assign fb_out = fn_res[0];

    dlut_combine u_gates (
        .mode  (mode),
        .f_a   (fn_res[1]),
        .f_b   (fn_res[0]),
        .bypass(bypass_in),
        .g_sel (gsel_out),
        .g_nand(gnand_out)
    );

    // R6: multiplexer steered by the bypass input
    p_mux_pick_r6: assert property (@(posedge clk) disable iff (rst)
        (mode.five_en && mode.gate_sel == GATE_MUX) |->
            (gsel_out == (bypass_in ? fa_out : fb_out)));

    // R7: three-way parity
    p_xor_parity_r7: assert property (@(posedge clk) disable iff (rst)
        (mode.five_en && mode.gate_sel == GATE_XOR) |->
            ($countones({gsel_out, fa_out, fb_out, bypass_in}) % 2 == 0));

    // R8: NAND low only when all three are high
    p_nand_low_r8: assert property (@(posedge clk) disable iff (rst)
        mode.five_en |-> (!gnand_out == (fa_out && fb_out && bypass_in)));

    // R9: gates silent in four-input operation
    p_gates_off_r9: assert property (@(posedge clk) disable iff (rst)
        !mode.five_en |-> (!gsel_out && !gnand_out));

    // R9: function A follows its low table in four-input operation
    p_four_lo_r9: assert property (@(posedge clk) disable iff (rst)
        !mode.five_en |-> (fa_out == tbl[TBL_A_LO][a_in[TBL_AW-1:0]]));

endmodule

// File: tb/dlut_cell_tb_top.sv
module dlut_cell_tb_top;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int CFG_W = 4 * DEPTH + 2;
    localparam int NIN   = 1 << (AW + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b0;
    logic cfg_din = 1'b0;
    logic [AW:0] a_in = '0;
    logic [AW:0] b_in = '0;
    logic bypass_in = 1'b0;
    logic fa_out, fb_out, gsel_out, gnand_out;

    int n_run  = 0;
    int n_fail = 0;
    logic [CFG_W-1:0] cur = '0;

    always #4 clk = ~clk;

    dlut_cell #(.TBL_AW(AW)) dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .a_in(a_in), .b_in(b_in), .bypass_in(bypass_in),
        .fa_out(fa_out), .fb_out(fb_out),
        .gsel_out(gsel_out), .gnand_out(gnand_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d c=%0b actual=%0b expected=%0b",
                     req, a_in, b_in, bypass_in, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [CFG_W-1:0] w);
        for (int i = CFG_W - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = w[i];
        end
        @(negedge clk);
        cfg_en  = 1'b0;
        cfg_din = 1'b0;
        cur     = w;
    endtask

    function automatic logic [CFG_W-1:0] make_cfg(input logic five, input logic xsel,
                                                  input logic [DEPTH-1:0] ahi, input logic [DEPTH-1:0] alo,
                                                  input logic [DEPTH-1:0] bhi, input logic [DEPTH-1:0] blo);
        return {five, xsel, ahi, alo, bhi, blo};
    endfunction

    // Exhaustive comparison against the requirement model of configuration cur.
    task automatic sweep(input string tag);
        logic five, xsel, ea, eb, eg, en;
        five = cur[CFG_W-1];
        xsel = cur[CFG_W-2];
        for (int a = 0; a < NIN; a++) begin
            for (int b = 0; b < NIN; b++) begin
                for (int c = 0; c < 2; c++) begin
                    a_in = a[AW:0]; b_in = b[AW:0]; bypass_in = c[0];
                    #1;
                    if (five) begin
                        ea = a_in[AW] ? cur[3*DEPTH + a_in[AW-1:0]] : cur[2*DEPTH + a_in[AW-1:0]];
                        eb = b_in[AW] ? cur[1*DEPTH + b_in[AW-1:0]] : cur[b_in[AW-1:0]];
                        eg = xsel ? (ea ^ eb ^ bypass_in) : (bypass_in ? ea : eb);
                        en = ~(ea & eb & bypass_in);
                        check({tag, " R4 R10 fa"}, fa_out, ea);
                        check({tag, " R5 R10 fb"}, fb_out, eb);
                        check({tag, xsel ? " R7 gsel" : " R6 gsel"}, gsel_out, eg);
                        check({tag, " R8 gnand"}, gnand_out, en);
                    end else begin
                        ea = cur[2*DEPTH + a_in[AW-1:0]];
                        eb = cur[b_in[AW-1:0]];
                        check({tag, " R9 fa"}, fa_out, ea);
                        check({tag, " R9 fb"}, fb_out, eb);
                        check({tag, " R9 gsel"}, gsel_out, 1'b0);
                        check({tag, " R9 gnand"}, gnand_out, 1'b0);
                    end
                end
            end
        end
    endtask

    task automatic t_reset_state();
        cur = '0;
        a_in = '1; b_in = '1; bypass_in = 1'b1; #1;
        check("R1 fa reset", fa_out, 1'b0);
        check("R1 fb reset", fb_out, 1'b0);
        check("R1 gsel reset", gsel_out, 1'b0);
        check("R1 gnand reset", gnand_out, 1'b0);
    endtask

    task automatic t_mux_mode();
        load_cfg(make_cfg(1'b1, 1'b0, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom)));
        sweep("R2 mux");
    endtask

    task automatic t_xor_mode();
        load_cfg(make_cfg(1'b1, 1'b1, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom)));
        sweep("R2 xor");
        // all-ones tables: NAND follows the bypass input only
        load_cfg(make_cfg(1'b1, 1'b1, '1, '1, '1, '1));
        sweep("R8 ones");
    endtask

    task automatic t_mux_fixed();
        load_cfg(make_cfg(1'b1, 1'b0, 16'hFF00, 16'h0F0F, 16'hAAAA, 16'h3C3C));
        sweep("R6 fixed");
    endtask

    task automatic t_four_mode();
        load_cfg(make_cfg(1'b0, 1'b1, 16'h1234, 16'h8E71, 16'hC0DE, 16'h5A96));
        sweep("R9 four");
    endtask

    task automatic t_hold_then_reset();
        logic [CFG_W-1:0] w;
        w = make_cfg(1'b1, 1'b0, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
        load_cfg(w);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            cfg_din = i[0] ^ i[2];
        end
        cfg_din = 1'b0;
        sweep("R3 hold");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        sweep("R1 after");
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_mux_mode();
        t_mux_fixed();
        t_xor_mode();
        t_four_mode();
        t_hold_then_reset();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule